// File: doc/BRIEF.md
# Control-Word Steered Single-Cycle Datapath

This block is the execution half of a small processor. It has a four-entry register file with two read ports and one write port, an ALU that reports four status flags, a word-addressed RAM, and two steering multiplexers. There is no instruction decoder. Every cycle, an external control word names the source registers, the destination register, the ALU function, whether a constant replaces the second operand, and whether the register file or the RAM is written. Each control word finishes in one clock.

The RAM is always addressed by the first read port. It always takes its write data from the second operand path, which is either read port B or the external constant. The ALU cannot reach memory directly. A memory value is loaded into a register, changed there, and stored back. The value to write back to a register comes either from the ALU result or from the RAM read data.

The registers and the current ALU result are brought out as plain outputs. A sequence such as load, increment and store can therefore be followed at the ports.

Top module: `dp_core`

## Requirements
- R1: The register file holds four registers. Register i appears on `regs_flat[i*W +: W]`. Reads through `srca_sel` and `srcb_sel` are combinational, so both operands reach the ALU in the same cycle.
- R2: A register changes only on a rising clock edge while `reg_we` is 1, and only the register named by `dst_sel` is written. When `reg_we` is 0, all registers keep their values.
- R3: The arithmetic function codes give these results on `alu_out`:
  - 00000: A
  - 00001: A+1
  - 00010: A+B
  - 00011: A+B+1
  - 00100: A+~B
  - 00101: A−B
  - 00110: A−1
- R4: The logic and shift codes give these results on `alu_out`, and they force `flag_v` and `flag_c` to 0:
  - 01000: A AND B
  - 01010: A OR B
  - 01100: A XOR B
  - 01110: NOT A
  - 10000: B
  - 10100: B shifted right with zero fill
  - 11000: B shifted left with zero fill
- R5: For every listed function code:
  - `flag_n` equals the result's top bit.
  - `flag_z` is 1 exactly when the result is zero.
  - For the arithmetic codes, `flag_c` is the carry out of the adder and `flag_v` marks signed overflow.
- R6: Any function code not listed in R3 or R4 gives a zero result with all four flags at 0.
- R7: With `mem_we` at 1, the second operand is written into RAM at the address held in the register selected by `srca_sel`, on the rising edge. With `mem_we` at 0, the RAM is left unchanged.
- R8: With `wb_mem_sel` at 0, the ALU result is written back to the register. With `wb_mem_sel` at 1, the combinational RAM read at the port-A address is written back instead, so a load finishes in one clock.
- R9: With `const_sel` at 1, `const_in` replaces read port B, both as the ALU B operand and as the RAM write data.
- R10: A synchronous `rst` clears every register and every RAM word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dst_sel | input | 2 | Destination register for write-back |
| srca_sel | input | 2 | Register driving the A operand and the RAM address |
| srcb_sel | input | 2 | Register driving read port B |
| func_sel | input | 5 | ALU function code |
| const_sel | input | 1 | 1 selects `const_in` in place of read port B |
| wb_mem_sel | input | 1 | 1 writes back RAM data, 0 writes back the ALU result |
| reg_we | input | 1 | Register write enable |
| mem_we | input | 1 | RAM write enable |
| const_in | input | W | External constant operand |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |
| alu_out | output | W | Current ALU result |
| regs_flat | output | 4*W | All four registers, register 0 in the low bits |

## Verification
The ALU result, the four flags and the RAM read data are combinational. They are due in the same cycle as the control word, so the bench applies each word one nanosecond after a rising edge and samples one nanosecond later. Register and RAM writes become visible only after the next rising edge. Each stored word is therefore checked after exactly one clock, by looking at `regs_flat` or by loading the word back into a register. A chained load, increment and store takes three edges, and each result is checked at its own edge.

// File: rtl/dp_pkg.sv
package dp_pkg;

  typedef enum logic [4:0] {
    FS_PASS_A = 5'b00000,
    FS_INC    = 5'b00001,
    FS_ADD    = 5'b00010,
    FS_ADDC   = 5'b00011,
    FS_ADDNB  = 5'b00100,
    FS_SUB    = 5'b00101,
    FS_DEC    = 5'b00110,
    FS_AND    = 5'b01000,
    FS_OR     = 5'b01010,
    FS_XOR    = 5'b01100,
    FS_NOTA   = 5'b01110,
    FS_PASS_B = 5'b10000,
    FS_SHR    = 5'b10100,
    FS_SHL    = 5'b11000
  } fs_e;

  function automatic logic fs_is_logic(logic [4:0] fs);
    return fs inside {FS_AND, FS_OR, FS_XOR, FS_NOTA, FS_PASS_B, FS_SHR, FS_SHL};
  endfunction

  function automatic logic fs_is_arith(logic [4:0] fs);
    return fs inside {FS_PASS_A, FS_INC, FS_ADD, FS_ADDC, FS_ADDNB, FS_SUB, FS_DEC};
  endfunction

endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [AW-1:0]            wsel,
  input  logic [W-1:0]             wdata,
  input  logic [AW-1:0]            asel,
  input  logic [AW-1:0]            bsel,
  output logic [W-1:0]             adata,
  output logic [W-1:0]             bdata,
  output logic [(1<<AW)-1:0]       load_vec,
  output logic [(1<<AW)*W-1:0]     flat
);
  localparam int NREG = 1 << AW;

  logic [W-1:0] regs [NREG];

  // decode destination, gated by write enable
  always_comb begin
    load_vec = '0;
    if (we) load_vec[wsel] = 1'b1;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)              regs[i] <= '0;
      else if (load_vec[i]) regs[i] <= wdata;
    end
    assign flat[i*W +: W] = regs[i];
  end

  assign adata = regs[asel];
  assign bdata = regs[bsel];

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   fs,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] f,
  output logic         v,
  output logic         c,
  output logic         n,
  output logic         z
);

  typedef struct packed {
    logic [W-1:0] f;
    logic         v;
    logic         c;
    logic         n;
    logic         z;
  } res_t;

  function automatic res_t alu_calc(logic [4:0] code, logic [W-1:0] x, logic [W-1:0] y);
    res_t         r;
    logic [W-1:0] bop;
    logic         cin;
    logic [W:0]   sum;
    r   = '0;
    bop = '0;
    cin = 1'b0;
    if (fs_is_arith(code)) begin
      case (code)
        FS_INC:   begin bop = '0; cin = 1'b1; end
        FS_ADD:   begin bop = y;  cin = 1'b0; end
        FS_ADDC:  begin bop = y;  cin = 1'b1; end
        FS_ADDNB: begin bop = ~y; cin = 1'b0; end
        FS_SUB:   begin bop = ~y; cin = 1'b1; end
        FS_DEC:   begin bop = '1; cin = 1'b0; end
        default:  begin bop = '0; cin = 1'b0; end
      endcase
      sum = {1'b0, x} + {1'b0, bop} + {{W{1'b0}}, cin};
      r.f = sum[W-1:0];
      r.c = sum[W];
      r.v = (x[W-1] == bop[W-1]) && (sum[W-1] != x[W-1]);
      r.n = r.f[W-1];
      r.z = (r.f == '0);
    end else if (fs_is_logic(code)) begin
      case (code)
        FS_AND:    r.f = x & y;
        FS_OR:     r.f = x | y;
        FS_XOR:    r.f = x ^ y;
        FS_NOTA:   r.f = ~x;
        FS_PASS_B: r.f = y;
        FS_SHR:    r.f = y >> 1;
        FS_SHL:    r.f = y << 1;
        default:   r.f = '0;
      endcase
      r.n = r.f[W-1];
      r.z = (r.f == '0);
    end
    return r;
  endfunction

  res_t res;
  always_comb res = alu_calc(fs, a, b);

  assign f = res.f;
  assign v = res.v;
  assign c = res.c;
  assign n = res.n;
  assign z = res.z;

endmodule

// File: rtl/dp_ram.sv
module dp_ram #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata
);
  localparam int DEPTH = 1 << W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/dp_core.sv
module dp_core #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [AW-1:0]          dst_sel,
  input  logic [AW-1:0]          srca_sel,
  input  logic [AW-1:0]          srcb_sel,
  input  logic [4:0]             func_sel,
  input  logic                   const_sel,
  input  logic                   wb_mem_sel,
  input  logic                   reg_we,
  input  logic                   mem_we,
  input  logic [W-1:0]           const_in,
  output logic                   flag_v,
  output logic                   flag_c,
  output logic                   flag_n,
  output logic                   flag_z,
  output logic [W-1:0]           alu_out,
  output logic [(1<<AW)*W-1:0]   regs_flat
);
  localparam int NREG = 1 << AW;

  // named internal events, observed by the bound checker
  logic [W-1:0]    a_data;
  logic [W-1:0]    b_data;
  logic [W-1:0]    b_mux;
  logic [W-1:0]    ram_rdata;
  logic [W-1:0]    wb_data;
  logic [NREG-1:0] reg_load;

  dp_regfile #(.W(W), .AW(AW)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .we       (reg_we),
    .wsel     (dst_sel),
    .wdata    (wb_data),
    .asel     (srca_sel),
    .bsel     (srcb_sel),
    .adata    (a_data),
    .bdata    (b_data),
    .load_vec (reg_load),
    .flat     (regs_flat)
  );

  assign b_mux = const_sel ? const_in : b_data;

  dp_alu #(.W(W)) u_alu (
    .fs (func_sel),
    .a  (a_data),
    .b  (b_mux),
    .f  (alu_out),
    .v  (flag_v),
    .c  (flag_c),
    .n  (flag_n),
    .z  (flag_z)
  );

  dp_ram #(.W(W)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we),
    .addr  (a_data),
    .wdata (b_mux),
    .rdata (ram_rdata)
  );

  assign wb_data = wb_mem_sel ? ram_rdata : alu_out;

endmodule

// File: rtl/dp_core_chk.sv
module dp_core_chk
  import dp_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   reg_we,
  input logic                   wb_mem_sel,
  input logic                   const_sel,
  input logic [4:0]             func_sel,
  input logic [W-1:0]           const_in,
  input logic [W-1:0]           b_mux,
  input logic [W-1:0]           ram_rdata,
  input logic [W-1:0]           alu_out,
  input logic [W-1:0]           wb_data,
  input logic [(1<<AW)-1:0]     reg_load,
  input logic [(1<<AW)*W-1:0]   regs_flat,
  input logic                   flag_v,
  input logic                   flag_c,
  input logic                   flag_n,
  input logic                   flag_z
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R2
  hold_regs_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_we |=> $stable(regs_flat));

  // R2
  single_load_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(reg_load) == (reg_we ? 1 : 0));

  // R4
  logic_flags_chk: assert property (@(posedge clk) disable iff (rst)
    fs_is_logic(func_sel) |-> (!flag_v && !flag_c));

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (fs_is_logic(func_sel) || fs_is_arith(func_sel)) |-> (flag_z == (alu_out == '0)));

  // R5
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (fs_is_logic(func_sel) || fs_is_arith(func_sel)) |-> (flag_n == alu_out[W-1]));

  // R6
  unlisted_chk: assert property (@(posedge clk) disable iff (rst)
    !(fs_is_logic(func_sel) || fs_is_arith(func_sel)) |->
      (alu_out == '0 && !flag_v && !flag_c && !flag_n && !flag_z));

  // R8
  wb_src_chk: assert property (@(posedge clk) disable iff (rst)
    wb_data == (wb_mem_sel ? ram_rdata : alu_out));

  // R9
  const_mux_chk: assert property (@(posedge clk) disable iff (rst)
    const_sel |-> (b_mux == const_in));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst_q |-> (regs_flat == '0));

endmodule

bind dp_core dp_core_chk #(.W(W), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_we     (reg_we),
  .wb_mem_sel (wb_mem_sel),
  .const_sel  (const_sel),
  .func_sel   (func_sel),
  .const_in   (const_in),
  .b_mux      (b_mux),
  .ram_rdata  (ram_rdata),
  .alu_out    (alu_out),
  .wb_data    (wb_data),
  .reg_load   (reg_load),
  .regs_flat  (regs_flat),
  .flag_v     (flag_v),
  .flag_c     (flag_c),
  .flag_n     (flag_n),
  .flag_z     (flag_z)
);

// File: tb/tb_dp_core.sv
`timescale 1ns/1ps
module tb_dp_core;
  localparam int W  = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    dst_sel, srca_sel, srcb_sel;
  logic [4:0]    func_sel;
  logic          const_sel, wb_mem_sel, reg_we, mem_we;
  logic [W-1:0]  const_in;
  logic          flag_v, flag_c, flag_n, flag_z;
  logic [W-1:0]  alu_out;
  logic [4*W-1:0] regs_flat;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  dp_core #(.W(W), .AW(AW)) dut (
    .clk(clk), .rst(rst), .dst_sel(dst_sel), .srca_sel(srca_sel),
    .srcb_sel(srcb_sel), .func_sel(func_sel), .const_sel(const_sel),
    .wb_mem_sel(wb_mem_sel), .reg_we(reg_we), .mem_we(mem_we),
    .const_in(const_in), .flag_v(flag_v), .flag_c(flag_c),
    .flag_n(flag_n), .flag_z(flag_z), .alu_out(alu_out),
    .regs_flat(regs_flat)
  );

  // {fs[4:0], a[7:0], b[7:0], result[7:0], vcnz[3:0]}
  localparam logic [32:0] VEC [17] = '{
    {5'b00010, 8'h7F, 8'h01, 8'h80, 4'b1010},
    {5'b00010, 8'hFF, 8'h01, 8'h00, 4'b0101},
    {5'b00001, 8'hFF, 8'h00, 8'h00, 4'b0101},
    {5'b00101, 8'h05, 8'h07, 8'hFE, 4'b0010},
    {5'b00101, 8'h80, 8'h01, 8'h7F, 4'b1100},
    {5'b00110, 8'h00, 8'h00, 8'hFF, 4'b0010},
    {5'b00011, 8'h10, 8'h20, 8'h31, 4'b0000},
    {5'b00100, 8'h10, 8'h0F, 8'h00, 4'b0101},
    {5'b01000, 8'hF0, 8'h3C, 8'h30, 4'b0000},
    {5'b01010, 8'hF0, 8'h0F, 8'hFF, 4'b0010},
    {5'b01100, 8'hAA, 8'hAA, 8'h00, 4'b0001},
    {5'b01110, 8'h0F, 8'h00, 8'hF0, 4'b0010},
    {5'b10000, 8'h00, 8'h80, 8'h80, 4'b0010},
    {5'b10100, 8'h00, 8'h81, 8'h40, 4'b0000},
    {5'b11000, 8'h00, 8'h81, 8'h02, 4'b0000},
    {5'b00000, 8'h00, 8'h00, 8'h00, 4'b0001},
    {5'b00111, 8'hFF, 8'hFF, 8'h00, 4'b0000}
  };

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    reg_we = 0; mem_we = 0; const_sel = 0; wb_mem_sel = 0;
    func_sel = 5'b00000; dst_sel = 0; srca_sel = 0; srcb_sel = 0; const_in = '0;
  endtask

  task automatic load_reg(logic [1:0] r, logic [W-1:0] val);
    idle();
    dst_sel = r; func_sel = 5'b10000; const_sel = 1; const_in = val; reg_we = 1;
    step();
    idle();
  endtask

  task automatic load_mem(logic [1:0] dst, logic [1:0] addr_reg);
    idle();
    srca_sel = addr_reg; wb_mem_sel = 1; dst_sel = dst; reg_we = 1;
    step();
    idle();
  endtask

  function automatic string tag_of(logic [4:0] fs);
    if (fs inside {5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b00100, 5'b00101, 5'b00110}) return "R3";
    if (fs inside {5'b01000, 5'b01010, 5'b01100, 5'b01110, 5'b10000, 5'b10100, 5'b11000}) return "R4";
    return "R6";
  endfunction

  function automatic logic [W-1:0] reg_of(int i);
    return regs_flat[i*W +: W];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    #1;
    step(); step();
    // R10 reset state
    chk("R10", "regs after reset", regs_flat, 0);
    chk("R10", "pass A of zero", {alu_out, flag_z}, {8'h00, 1'b1});
    rst = 0;

    // ALU table: R1 holds A, R2 holds B
    foreach (VEC[k]) begin
      load_reg(1, VEC[k][27:20]);
      load_reg(2, VEC[k][19:12]);
      srca_sel = 1; srcb_sel = 2; func_sel = VEC[k][32:28];
      #1;
      chk(tag_of(VEC[k][32:28]), "alu result", alu_out, VEC[k][11:4]);
      chk("R5", "flags vcnz", {flag_v, flag_c, flag_n, flag_z}, VEC[k][3:0]);
      idle();
    end

    // R1 register placement and two simultaneous reads
    load_reg(0, 8'h11); load_reg(1, 8'h22); load_reg(2, 8'h33); load_reg(3, 8'h44);
    chk("R1", "register placement", regs_flat, 32'h44332211);
    srca_sel = 3; srcb_sel = 0; func_sel = 5'b01010; #1;
    chk("R1", "dual read OR", alu_out, 8'h55);
    idle();

    // R2 write disabled leaves all registers
    dst_sel = 1; func_sel = 5'b10000; const_sel = 1; const_in = 8'hEE; reg_we = 0;
    step();
    chk("R2", "no write without enable", regs_flat, 32'h44332211);
    idle();
    load_reg(2, 8'hEE);
    chk("R2", "only destination written", regs_flat, 32'h44EE2211);

    // R9 constant feeds ALU B operand
    srca_sel = 0; srcb_sel = 3; const_sel = 1; const_in = 8'h05; func_sel = 5'b00010; #1;
    chk("R9", "const as B operand", alu_out, 8'h16);
    idle();

    // R7 R8 load, increment, store back
    load_reg(0, 8'h20);
    load_reg(1, 8'h5A);
    srca_sel = 0; srcb_sel = 1; mem_we = 1;
    step();
    idle();
    load_mem(3, 0);
    chk("R8", "load completes in one clock", reg_of(3), 8'h5A);
    srca_sel = 3; func_sel = 5'b00001; dst_sel = 3; reg_we = 1;
    step();
    idle();
    chk("R8", "ALU write-back", reg_of(3), 8'h5B);
    srca_sel = 0; srcb_sel = 3; mem_we = 1;
    step();
    idle();
    load_mem(2, 0);
    chk("R7", "store back to same address", reg_of(2), 8'h5B);

    // R9 constant as RAM write data
    srca_sel = 0; const_sel = 1; const_in = 8'h77; mem_we = 1;
    step();
    idle();
    load_mem(1, 0);
    chk("R9", "const stored to RAM", reg_of(1), 8'h77);

    // R7 mem_we low leaves RAM
    srca_sel = 0; srcb_sel = 2; mem_we = 0;
    step();
    idle();
    load_mem(1, 0);
    chk("R7", "RAM unchanged without enable", reg_of(1), 8'h77);

    // R10 reset clears RAM too
    rst = 1;
    step();
    rst = 0;
    chk("R10", "regs cleared again", regs_flat, 0);
    load_reg(0, 8'h20);
    load_mem(1, 0);
    chk("R10", "RAM word cleared", reg_of(1), 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule